// File: doc/BRIEF.md
# Reset-Time Bus Configuration Latch

This block reads a 16-bit data bus while the system reset input is held low. It turns the bus value into registered configuration outputs. These outputs tell the rest of the chip how to use its shared pins: which chip-select groups act as chip-selects and which act as upper address lines, how wide the boot memory port is, whether the bus-control pins and the interrupt pins keep their normal function or go to general I/O ports, and whether factory test mode is on.

Any bus line that nothing drives is pulled high, so an idle bus gives the default setup: every chip-select active, a 16-bit boot port, normal control and interrupt pins, and no test mode. A board picks a different setup by pulling chosen data lines low during reset.

After reset is released, the block takes one last sample. From then on it ignores the bus, and its outputs hold until the next reset.

Top module: `boot_cfg_latch`

## Requirements
- R1: If the bus reads all ones at capture, the outputs are: every chip-select enable 1, `boot_port16`=1, `ctrl_bus_en`=1, `irq_bus_en`=1 and `test_mode`=0.
- R2: `boot_port16` equals captured bit 0. A value of 1 means a 16-bit boot port and 0 means an 8-bit boot port.
- R3: `boot_cs_en` is 0 after any clock edge that sees reset low. It becomes 1 at the first clock edge that sees reset high.
- R4: `cs_lo_en` (chip-selects 0..2) equals captured bit 1. `cs_mid_en` (chip-selects 3..5) equals captured bit 2. For both outputs, 1 means chip-select and 0 means the alternate address function.
- R5: `cs_hi_en[k]` drives chip-select 6+k, for k from 0 to 4. It is 1 only when captured bits 3+k up to 7 are all 1. So a low bit n (3..7) turns chip-select n+3 and every lower one down to chip-select 6 into address lines.
- R6: `ctrl_bus_en` equals captured bit 8. A value of 0 gives the data-acknowledge, autovector, strobe and size pins to I/O port E.
- R7: `irq_bus_en` equals captured bit 9. A value of 0 gives the eight interrupt request pins and the clock mode pin to I/O port F.
- R8: `test_mode` is the inverse of captured bit 11, so a low bit 11 selects factory test mode.
- R9: At every clock edge that sees reset low, the outputs load a decode of the bus. The outputs then decode the bus value present at the first edge that sees reset high. After that, changes on the bus have no effect until reset is asserted again.
- R10: Bits 10 and 12..15 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, sampled on the clock |
| bus_in | input | 16 | Data bus read during reset |
| boot_cs_en | output | 1 | Boot chip-select enabled |
| boot_port16 | output | 1 | 1: 16-bit boot port, 0: 8-bit |
| cs_lo_en | output | 1 | Chip-selects 0..2 used as chip-selects |
| cs_mid_en | output | 1 | Chip-selects 3..5 used as chip-selects |
| cs_hi_en | output | 5 | Bit k: chip-select 6+k used as chip-select |
| ctrl_bus_en | output | 1 | Bus-control pins keep their function |
| irq_bus_en | output | 1 | Interrupt pins keep their function |
| test_mode | output | 1 | Factory test mode |

## Verification
The assertions check the following on every cycle:
- The outputs hold still once capture has happened.
- The upper chip-select enables stay ordered, so a cleared group never sits above a set one.
- The boot enable is low in reset and rises at the capture edge.
- The captured boot width matches the bus bit seen on that edge.

The bench's scenarios show the rest:
- The decode of each bit against a reference model, including all 32 cascade patterns.
- That the final sample, and not an earlier reset value, wins.
- That bus toggling after capture and the spare bits leave the outputs unchanged.

// File: rtl/boot_cfg_latch.sv
module boot_cfg_latch #(
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned HI_GROUPS = 5,
  parameter int unsigned HI_BASE   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BUS_W-1:0]     bus_in,
  output logic                 boot_cs_en,
  output logic                 boot_port16,
  output logic                 cs_lo_en,
  output logic                 cs_mid_en,
  output logic [HI_GROUPS-1:0] cs_hi_en,
  output logic                 ctrl_bus_en,
  output logic                 irq_bus_en,
  output logic                 test_mode
);
  localparam int unsigned BIT_PORT = 0;
  localparam int unsigned BIT_LO   = 1;
  localparam int unsigned BIT_MID  = 2;
  localparam int unsigned HI_TOP   = HI_BASE + HI_GROUPS - 1;
  localparam int unsigned BIT_CTRL = 8;
  localparam int unsigned BIT_IRQ  = 9;
  localparam int unsigned BIT_TEST = 11;

  logic locked;
  logic load;
  logic [HI_GROUPS-1:0] hi_dec;

  assign load = !rst_n || !locked;

  for (genvar k = 0; k < HI_GROUPS; k++) begin : g_cascade
    assign hi_dec[k] = &bus_in[HI_TOP:HI_BASE+k];
  end

  wire unused_spare = ^{bus_in[BUS_W-1:BIT_TEST+1], bus_in[BIT_TEST-1]};

  always_ff @(posedge clk) begin
    locked     <= rst_n;
    boot_cs_en <= rst_n;
    if (load) begin
      boot_port16 <= bus_in[BIT_PORT];
      cs_lo_en    <= bus_in[BIT_LO];
      cs_mid_en   <= bus_in[BIT_MID];
      cs_hi_en    <= hi_dec;
      ctrl_bus_en <= bus_in[BIT_CTRL];
      irq_bus_en  <= bus_in[BIT_IRQ];
      test_mode   <= !bus_in[BIT_TEST];
    end
  end

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked && $past(locked) |->
      $stable({boot_port16, cs_lo_en, cs_mid_en, cs_hi_en, ctrl_bus_en, irq_bus_en, test_mode}));

  a_r9_capture_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> boot_port16 == $past(bus_in[BIT_PORT]));

  a_r3_boot_on: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> boot_cs_en && locked);

  a_r3_boot_off: assert property (@(posedge clk)
    !rst_n |=> !boot_cs_en);

  for (genvar k = 0; k + 1 < HI_GROUPS; k++) begin : g_chk
    a_r5_cascade_order: assert property (@(posedge clk) disable iff (!rst_n)
      locked && cs_hi_en[k] |-> cs_hi_en[k+1]);
  end
endmodule

// File: tb/boot_cfg_latch_bench.sv
module boot_cfg_latch_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] bus_in = 16'hFFFF;
  logic boot_cs_en, boot_port16, cs_lo_en, cs_mid_en, ctrl_bus_en, irq_bus_en, test_mode;
  logic [4:0] cs_hi_en;

  always #4 clk = ~clk;

  boot_cfg_latch u_boot_cfg_latch (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .boot_cs_en(boot_cs_en), .boot_port16(boot_port16),
    .cs_lo_en(cs_lo_en), .cs_mid_en(cs_mid_en), .cs_hi_en(cs_hi_en),
    .ctrl_bus_en(ctrl_bus_en), .irq_bus_en(irq_bus_en), .test_mode(test_mode)
  );

  int checks = 0;
  int errors = 0;
  int edges = 0;
  bit armed = 0;

  logic [15:0] m_word;
  bit m_done;
  bit m_boot;

  always @(posedge clk) begin
    edges <= edges + 1;
    if (rst_n == 0) begin
      m_word <= bus_in; m_done <= 0; m_boot <= 0;
    end else if (!m_done) begin
      m_word <= bus_in; m_done <= 1; m_boot <= 1;
    end
  end

  function automatic logic [4:0] ref_hi(input logic [15:0] w);
    logic [4:0] r;
    for (int g = 0; g < 5; g++) begin
      r[g] = 1'b1;
      for (int b = g + 3; b <= 7; b++) if (!w[b]) r[g] = 1'b0;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk("R3 boot_cs_en", {4'b0, boot_cs_en}, {4'b0, m_boot});
    chk("R2 boot_port16", {4'b0, boot_port16}, {4'b0, m_word[0]});
    chk("R4 cs_lo_en", {4'b0, cs_lo_en}, {4'b0, m_word[1]});
    chk("R4 cs_mid_en", {4'b0, cs_mid_en}, {4'b0, m_word[2]});
    chk("R5 cs_hi_en", cs_hi_en, ref_hi(m_word));
    chk("R6 ctrl_bus_en", {4'b0, ctrl_bus_en}, {4'b0, m_word[8]});
    chk("R7 irq_bus_en", {4'b0, irq_bus_en}, {4'b0, m_word[9]});
    chk("R8 test_mode", {4'b0, test_mode}, {4'b0, ~m_word[11]});
  end

  task automatic run_case(input logic [15:0] rst_val, input logic [15:0] cap_val);
    @(negedge clk); rst_n = 0; bus_in = rst_val;
    repeat (3) @(negedge clk);
    rst_n = 1; bus_in = cap_val;
    @(negedge clk);
    bus_in = ~cap_val;
    @(negedge clk);
    bus_in = 16'h0000;
    @(negedge clk);
    bus_in = 16'h5A5A ^ cap_val;
    @(negedge clk);
    chk("R9 frozen boot_port16", {4'b0, boot_port16}, {4'b0, cap_val[0]});
    chk("R9 frozen cs_hi_en", cs_hi_en, ref_hi(cap_val));
  endtask

  initial begin
    rst_n = 0; bus_in = 16'hFFFF;
    repeat (2) @(negedge clk);
    armed = 1;
    chk("R3 reset boot_cs_en", {4'b0, boot_cs_en}, 5'd0);

    run_case(16'h0000, 16'hFFFF);
    chk("R1 default", {boot_port16, cs_lo_en, cs_mid_en, ctrl_bus_en, irq_bus_en}, 5'b11111);
    chk("R1 default hi", cs_hi_en, 5'b11111);
    chk("R1 default test", {4'b0, test_mode}, 5'd0);

    run_case(16'hFFFF, 16'hFFFE);
    chk("R2 8-bit port", {4'b0, boot_port16}, 5'd0);
    run_case(16'hFFFF, 16'hFFFD);
    chk("R4 lo alt", {4'b0, cs_lo_en}, 5'd0);
    run_case(16'hFFFF, 16'hFFFB);
    chk("R4 mid alt", {4'b0, cs_mid_en}, 5'd0);
    run_case(16'hFFFF, 16'hFEFF);
    chk("R6 port E", {4'b0, ctrl_bus_en}, 5'd0);
    run_case(16'hFFFF, 16'hFDFF);
    chk("R7 port F", {4'b0, irq_bus_en}, 5'd0);
    run_case(16'hFFFF, 16'hF7FF);
    chk("R8 test on", {4'b0, test_mode}, 5'd1);

    for (int p = 0; p < 32; p++) begin
      logic [15:0] w;
      w = 16'hFFFF;
      w[7:3] = p[4:0];
      run_case(~w, w);
      chk("R5 cascade", cs_hi_en, ref_hi(w));
    end
    run_case(16'hFFFF, 16'hFFDF);
    chk("R5 bit5 low", cs_hi_en, 5'b11000);

    run_case(16'h0000, 16'h0BFF);
    chk("R10 spare bits", {boot_port16, cs_lo_en, cs_mid_en, ctrl_bus_en, irq_bus_en}, 5'b11111);
    chk("R10 spare hi", cs_hi_en, 5'b11111);
    chk("R10 spare test", {4'b0, test_mode}, 5'd0);

    run_case(16'h0000, 16'h1234);
    chk("R9 final sample wins", {4'b0, boot_port16}, 5'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) if (edges > 20000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected<=20000", edges);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule